// File: doc/BRIEF.md
# Performance Counter CSR Bank

This block holds the 64-bit event counters of a 32-bit core: a free-running cycle counter, a retired-instruction counter and a parameterised set of event counters. Each event counter has its own selector that chooses one of the core's event strobes. Because the core's registers are 32 bits wide, each counter appears at two CSR addresses, one for its lower word and one for its upper word. Software can write either word at any time.

A 32-bit access-enable register has one bit per counter. At the top privilege level every CSR in the bank can be read and written. At any lower privilege level, a counter word can only be read, and only when that counter's enable bit is set. Every other lower-privilege access raises an illegal-access flag and returns zero. The enable bits control access only: counting is never paused. Event slots beyond a configured number are not built. They read as zero with a zero selector.

Top module: `hpm_csr_bank`

## Requirements
- R1: While reset is asserted, and right after it, all counter words, all selectors and the enable register read zero at the top privilege level (`priv_i == 2'b11`).
- R2: The cycle counter (index 0) increases by one on every clock edge on which it is not written.
- R3: The retired-instruction counter (index 1) increases by one on every clock edge where `retire_i` is high and it is not written.
- R4: Event counter e (index 2+e) increases by one on each edge where `evt_i[s-1]` is high, s being its selector value. A selector of 0, or above the number of strobes, never counts.
- R5: Counter words sit at 0x700+index (bits 31:0) and 0x780+index (bits 63:32). A carry out of the lower word increments the upper word.
- R6: A write to either word of a counter replaces that word on the next edge and keeps the other word. The increment of that edge is dropped.
- R7: The enable register is at 0x7F0 and its bit i belongs to counter index i. Bits at or above the counter count read zero. A lower-privilege read of a counter word returns the value with the flag low when the bit is set. It returns zero with `csr_illegal_o` high when the bit is clear.
- R8: At lower privilege, any write in the bank, and any read of a selector (0x7C0+e) or of the enable register, raises `csr_illegal_o`, returns zero and changes no state.
- R9: Writing the enable register leaves counter values untouched. Counters whose bit is clear keep counting.
- R10: Event slots with e at or above `NUM_IMPL` read zero in both words and in their selector, and ignore writes and strobes.
- R11: An address outside the bank returns zero, leaves `csr_illegal_o` low and has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| csr_valid_i | input | 1 | CSR access this cycle |
| csr_we_i | input | 1 | Access is a write |
| csr_addr_i | input | 12 | CSR address |
| csr_wdata_i | input | 32 | Write data |
| priv_i | input | 2 | Current privilege level, 2'b11 is top |
| retire_i | input | 1 | One instruction retired this cycle |
| evt_i | input | NUM_SRC | Event strobes |
| csr_rdata_o | output | 32 | Read data, combinational from the address |
| csr_illegal_o | output | 1 | Access not permitted, combinational |

## Verification
A corrupted counter shows up on the next read of its word. The bench predicts every read value exactly from the cycle count since the last write, so a dropped or doubled increment, a missed carry, or an increment applied during a write is off by at least one at the first read. A wrong enable bit or decode shows up in the same cycle, in `csr_illegal_o` and the zeroed data. Ignored writes are checked by a read at the top privilege level on the following cycles.

// File: rtl/hpm_pkg.sv
`timescale 1ns/1ps
package hpm_pkg;
  localparam logic [11:0] LO_BASE  = 12'h700;
  localparam logic [11:0] HI_BASE  = 12'h780;
  localparam logic [11:0] SEL_BASE = 12'h7C0;
  localparam logic [11:0] EN_ADDR  = 12'h7F0;
  localparam logic [1:0]  PRIV_TOP = 2'b11;

  typedef enum logic [2:0] {
    K_NONE,
    K_LO,
    K_HI,
    K_SEL,
    K_EN
  } kind_e;
endpackage

// File: rtl/hpm_decode.sv
`timescale 1ns/1ps
module hpm_decode import hpm_pkg::*; #(
  parameter int NUM_CNT = 6,
  parameter int NUM_EVT = 4,
  parameter int IDX_W   = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic               we_i,
  input  logic [11:0]        addr_i,
  input  logic [1:0]         priv_i,
  input  logic [NUM_CNT-1:0] en_i,
  output kind_e              kind_o,
  output logic [IDX_W-1:0]   idx_o,
  output logic               legal_o,
  output logic               illegal_o
);
  localparam logic [11:0] CNT12 = 12'(NUM_CNT);
  localparam logic [11:0] EVT12 = 12'(NUM_EVT);

  logic [11:0] off_lo, off_hi, off_sel;
  logic        top, lower_ok, hit, allow;

  always_comb begin
    off_lo  = addr_i - LO_BASE;
    off_hi  = addr_i - HI_BASE;
    off_sel = addr_i - SEL_BASE;
    kind_o  = K_NONE;
    idx_o   = '0;
    if (off_lo < CNT12) begin
      kind_o = K_LO;
      idx_o  = off_lo[IDX_W-1:0];
    end else if (off_hi < CNT12) begin
      kind_o = K_HI;
      idx_o  = off_hi[IDX_W-1:0];
    end else if (off_sel < EVT12) begin
      kind_o = K_SEL;
      idx_o  = off_sel[IDX_W-1:0];
    end else if (addr_i == EN_ADDR) begin
      kind_o = K_EN;
    end
  end

  assign top       = (priv_i == PRIV_TOP);
  assign hit       = (kind_o != K_NONE);
  assign lower_ok  = !we_i && (kind_o == K_LO || kind_o == K_HI) && en_i[idx_o];
  assign allow     = top || lower_ok;
  assign legal_o   = valid_i && hit && allow;
  assign illegal_o = valid_i && hit && !allow;

  assert_low_write_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && we_i && priv_i != PRIV_TOP && addr_i == EN_ADDR) |-> illegal_o);

  assert_low_cfg_read_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && priv_i != PRIV_TOP && kind_o == K_SEL) |-> !legal_o);
endmodule

// File: rtl/hpm_counter.sv
`timescale 1ns/1ps
module hpm_counter #(
  parameter int CNT_W = 64,
  localparam int HALF = CNT_W / 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic             wr_lo_i,
  input  logic             wr_hi_i,
  input  logic [HALF-1:0]  wdata_i,
  output logic [CNT_W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_o <= '0;
    else if (wr_lo_i) cnt_o[HALF-1:0] <= wdata_i;
    else if (wr_hi_i) cnt_o[CNT_W-1:HALF] <= wdata_i;
    else if (inc_i)   cnt_o <= cnt_o + 1'b1;
  end

  assert_write_wins_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_lo_i |=> (cnt_o[HALF-1:0] == $past(wdata_i)) &&
                (cnt_o[CNT_W-1:HALF] == $past(cnt_o[CNT_W-1:HALF])));

  assert_write_hi_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_hi_i && !wr_lo_i) |=> (cnt_o[CNT_W-1:HALF] == $past(wdata_i)) &&
                              (cnt_o[HALF-1:0] == $past(cnt_o[HALF-1:0])));

  assert_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !wr_lo_i && !wr_hi_i) |=> cnt_o == $past(cnt_o) + 1'b1);

  assert_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!inc_i && !wr_lo_i && !wr_hi_i) |=> $stable(cnt_o));
endmodule

// File: rtl/hpm_event_sel.sv
`timescale 1ns/1ps
module hpm_event_sel #(
  parameter int NUM_SRC = 8,
  parameter int SEL_W   = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_i,
  input  logic [SEL_W-1:0]   wdata_i,
  input  logic [NUM_SRC-1:0] evt_i,
  output logic [SEL_W-1:0]   sel_o,
  output logic               fire_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   sel_o <= '0;
    else if (wr_i) sel_o <= wdata_i;
  end

  // value k selects strobe k-1; 0 and out-of-range values select nothing
  always_comb begin
    fire_o = 1'b0;
    for (int k = 0; k < NUM_SRC; k++) begin
      if (sel_o == SEL_W'(k + 1)) fire_o = evt_i[k];
    end
  end

  assert_sel_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_o == '0) |-> !fire_o);

  assert_no_strobe_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i == '0) |-> !fire_o);
endmodule

// File: rtl/hpm_csr_bank.sv
`timescale 1ns/1ps
module hpm_csr_bank import hpm_pkg::*; #(
  parameter int NUM_EVT  = 4,
  parameter int NUM_IMPL = 3,
  parameter int NUM_SRC  = 8,
  parameter int CNT_W    = 64,
  localparam int XLEN    = CNT_W / 2,
  localparam int NUM_CNT = 2 + NUM_EVT,
  localparam int SEL_W   = $clog2(NUM_SRC + 1),
  localparam int IDX_W   = $clog2(NUM_CNT)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               csr_valid_i,
  input  logic               csr_we_i,
  input  logic [11:0]        csr_addr_i,
  input  logic [XLEN-1:0]    csr_wdata_i,
  input  logic [1:0]         priv_i,
  input  logic               retire_i,
  input  logic [NUM_SRC-1:0] evt_i,
  output logic [XLEN-1:0]    csr_rdata_o,
  output logic               csr_illegal_o
);
  kind_e              kind;
  logic [IDX_W-1:0]   idx;
  logic               legal, wr_ok;
  logic [NUM_CNT-1:0] en_q;
  logic [CNT_W-1:0]   cnt_q [NUM_CNT];
  logic [SEL_W-1:0]   sel_q [NUM_EVT];
  logic [NUM_IMPL-1:0] fire;

  hpm_decode #(.NUM_CNT(NUM_CNT), .NUM_EVT(NUM_EVT), .IDX_W(IDX_W)) i_decode (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .valid_i   (csr_valid_i),
    .we_i      (csr_we_i),
    .addr_i    (csr_addr_i),
    .priv_i    (priv_i),
    .en_i      (en_q),
    .kind_o    (kind),
    .idx_o     (idx),
    .legal_o   (legal),
    .illegal_o (csr_illegal_o)
  );

  assign wr_ok = legal && csr_we_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     en_q <= '0;
    else if (wr_ok && kind == K_EN)  en_q <= csr_wdata_i[NUM_CNT-1:0];
  end

  for (genvar e = 0; e < NUM_EVT; e++) begin : g_sel
    if (e < NUM_IMPL) begin : g_on
      logic wr_sel;
      assign wr_sel = wr_ok && kind == K_SEL && idx == IDX_W'(e);
      hpm_event_sel #(.NUM_SRC(NUM_SRC), .SEL_W(SEL_W)) i_sel (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .wr_i    (wr_sel),
        .wdata_i (csr_wdata_i[SEL_W-1:0]),
        .evt_i   (evt_i),
        .sel_o   (sel_q[e]),
        .fire_o  (fire[e])
      );
    end else begin : g_off
      assign sel_q[e] = '0;
    end
  end

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    if (i < 2 + NUM_IMPL) begin : g_on
      logic inc, wr_lo, wr_hi;
      assign wr_lo = wr_ok && kind == K_LO && idx == IDX_W'(i);
      assign wr_hi = wr_ok && kind == K_HI && idx == IDX_W'(i);
      if (i == 0) begin : g_cyc
        assign inc = 1'b1;
      end else if (i == 1) begin : g_ret
        assign inc = retire_i;
      end else begin : g_evt
        assign inc = fire[i-2];
      end
      hpm_counter #(.CNT_W(CNT_W)) i_cnt (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .inc_i   (inc),
        .wr_lo_i (wr_lo),
        .wr_hi_i (wr_hi),
        .wdata_i (csr_wdata_i),
        .cnt_o   (cnt_q[i])
      );
    end else begin : g_off
      assign cnt_q[i] = '0;
    end
  end

  always_comb begin
    csr_rdata_o = '0;
    if (legal) begin
      unique case (kind)
        K_LO:    csr_rdata_o = cnt_q[idx][XLEN-1:0];
        K_HI:    csr_rdata_o = cnt_q[idx][CNT_W-1:XLEN];
        K_SEL:   csr_rdata_o = XLEN'(sel_q[idx]);
        K_EN:    csr_rdata_o = XLEN'(en_q);
        default: csr_rdata_o = '0;
      endcase
    end
  end

  assert_illegal_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    csr_illegal_o |-> csr_rdata_o == '0);

  assert_en_no_touch_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ok && kind == K_EN) |=> cnt_q[0] == $past(cnt_q[0]) + 1'b1);

  assert_unmapped_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_valid_i && kind == K_NONE) |-> (!csr_illegal_o && csr_rdata_o == '0));
endmodule

// File: tb/test_hpm_csr_bank.sv
`timescale 1ns/1ps
module test_hpm_csr_bank;
  localparam logic [1:0] T = 2'b11;
  localparam logic [1:0] L = 2'b00;
  localparam logic [11:0] LO = 12'h700, HI = 12'h780, SEL = 12'h7C0, EN = 12'h7F0;

  logic        clk, rst_ni;
  logic        valid, we, retire;
  logic [11:0] addr;
  logic [31:0] wdata, rdata;
  logic [1:0]  priv;
  logic [7:0]  evt;
  logic        illegal;

  typedef struct {
    logic [31:0] data;
    logic        ill;
    bit          chk_data;
    string       tag;
  } item_t;

  item_t q[$];
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  hpm_csr_bank i_hpm_csr_bank (
    .clk_i (clk), .rst_ni (rst_ni), .csr_valid_i (valid), .csr_we_i (we),
    .csr_addr_i (addr), .csr_wdata_i (wdata), .priv_i (priv), .retire_i (retire),
    .evt_i (evt), .csr_rdata_o (rdata), .csr_illegal_o (illegal)
  );

  initial begin
    clk = 0;
    forever #10 clk = ~clk;
  end

  task automatic rd(input logic [11:0] a, input logic [1:0] p,
                    input logic [31:0] exp, input logic ill, input string tag);
    item_t it;
    @(negedge clk);
    valid = 1; we = 0; addr = a; priv = p;
    it.data = exp; it.ill = ill; it.chk_data = 1; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic [1:0] p,
                    input logic ill, input string tag);
    item_t it;
    @(negedge clk);
    valid = 1; we = 1; addr = a; wdata = d; priv = p;
    it.data = 0; it.ill = ill; it.chk_data = 0; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic cyc(input logic r, input logic [7:0] e);
    @(negedge clk);
    valid = 0; we = 0; retire = r; evt = e;
  endtask

  // monitor: samples a quarter period after each falling edge
  initial begin
    forever begin
      @(negedge clk);
      #5;
      if (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        n_chk++;
        if (illegal !== it.ill || (it.chk_data && rdata !== it.data)) begin
          n_fail++;
          $display("FAIL %s: data=%h ill=%b expected data=%h ill=%b",
                   it.tag, rdata, illegal, it.data, it.ill);
        end
      end
    end
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_ni = 1; valid = 0; we = 0; addr = 0; wdata = 0; priv = T; retire = 0; evt = 0;
    #2 rst_ni = 0;
    // R1 reset state
    rd(LO + 0, T, 32'h0, 0, "R1 cycle lo");
    rd(HI + 1, T, 32'h0, 0, "R1 instret hi");
    rd(EN, T, 32'h0, 0, "R1 enable");
    rd(SEL + 0, T, 32'h0, 0, "R1 selector");
    @(negedge clk); rst_ni = 1; valid = 0;
    // R6 / R2
    wr(LO + 0, 32'h100, T, 0, "R6 wr lo");
    wr(HI + 0, 32'h0, T, 0, "R6 wr hi");
    rd(LO + 0, T, 32'h100, 0, "R6 increment dropped");
    cyc(0, 0); cyc(0, 0); cyc(0, 0);
    rd(LO + 0, T, 32'h104, 0, "R2 cycle count");
    // R5 carry
    wr(HI + 0, 32'h5, T, 0, "R5 wr hi");
    wr(LO + 0, 32'hFFFF_FFFE, T, 0, "R5 wr lo");
    rd(LO + 0, T, 32'hFFFF_FFFE, 0, "R5 lo word");
    rd(HI + 0, T, 32'h5, 0, "R5 hi before carry");
    rd(LO + 0, T, 32'h0, 0, "R5 lo wrapped");
    rd(HI + 0, T, 32'h6, 0, "R5 hi after carry");
    // R3 instret
    wr(LO + 1, 32'h0, T, 0, "R3 clear");
    repeat (5) cyc(1, 0);
    cyc(0, 0);
    rd(LO + 1, T, 32'h5, 0, "R3 retire count");
    cyc(1, 0);
    wr(LO + 1, 32'd10, T, 0, "R6 wr during retire");
    cyc(0, 0);
    rd(LO + 1, T, 32'd10, 0, "R6 retire dropped");
    // R4 events
    wr(SEL + 0, 32'd3, T, 0, "R4 sel0");
    wr(LO + 2, 32'h0, T, 0, "R4 clr2");
    rd(SEL + 0, T, 32'd3, 0, "R4 sel readback");
    cyc(0, 8'h04); cyc(0, 8'hFB); cyc(0, 8'h04); cyc(0, 8'hFB);
    cyc(0, 8'h04); cyc(0, 8'hFB); cyc(0, 8'h04); cyc(0, 8'h00);
    rd(LO + 2, T, 32'd4, 0, "R4 selected strobe count");
    wr(SEL + 1, 32'd12, T, 0, "R4 sel1 out of range");
    wr(LO + 3, 32'h0, T, 0, "R4 clr3");
    cyc(0, 8'hFF); cyc(0, 8'hFF); cyc(0, 8'hFF); cyc(0, 8'h00);
    rd(LO + 3, T, 32'h0, 0, "R4 out-of-range selector");
    rd(LO + 4, T, 32'h0, 0, "R4 zero selector");
    // R10 unimplemented slot
    wr(SEL + 3, 32'd1, T, 0, "R10 wr sel");
    wr(LO + 5, 32'h77, T, 0, "R10 wr cnt");
    cyc(0, 8'hFF); cyc(0, 8'h00);
    rd(LO + 5, T, 32'h0, 0, "R10 lo");
    rd(HI + 5, T, 32'h0, 0, "R10 hi");
    rd(SEL + 3, T, 32'h0, 0, "R10 sel");
    // R7 privilege gating
    wr(EN, 32'hFFFF_FFFF, T, 0, "R7 wr en all");
    rd(EN, T, 32'h3F, 0, "R7 en upper bits zero");
    wr(EN, 32'h1, T, 0, "R7 wr en cycle");
    wr(LO + 0, 32'h2000, T, 0, "R7 wr cycle");
    rd(LO + 0, L, 32'h2000, 0, "R7 lower read enabled");
    rd(LO + 1, L, 32'h0, 1, "R7 lower read disabled");
    // R8 lower writes and config reads
    wr(LO + 0, 32'h55, L, 1, "R8 lower write");
    rd(LO + 0, T, 32'h2003, 0, "R8 write ignored");
    rd(EN, L, 32'h0, 1, "R8 lower en read");
    rd(SEL + 0, L, 32'h0, 1, "R8 lower sel read");
    wr(EN, 32'h0, L, 1, "R8 lower en write");
    rd(EN, T, 32'h1, 0, "R8 en unchanged");
    // R9 enable writes leave counters alone
    wr(LO + 0, 32'h3000, T, 0, "R9 wr cycle");
    wr(EN, 32'h0, T, 0, "R9 wr en");
    rd(LO + 0, T, 32'h3001, 0, "R9 cycle after en write");
    cyc(1, 0); cyc(1, 0); cyc(0, 0);
    rd(LO + 1, L, 32'h0, 1, "R9 instret inaccessible");
    rd(LO + 1, T, 32'd12, 0, "R9 counted while inaccessible");
    // R11 unmapped
    rd(12'h123, T, 32'h0, 0, "R11 unmapped read");
    wr(12'h123, 32'hDEAD, T, 0, "R11 unmapped write");
    rd(LO + 1, T, 32'd12, 0, "R11 no side effect");
    cyc(0, 0); cyc(0, 0);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule